// File: doc/BRIEF.md
# Bit-Selected Reset PWM Generator

This block produces one pulse-width-modulated output from an 8-bit counter that moves forward on each cycle where a 32 kHz tick enable is high. The period is not set by comparing against a terminal count. Instead, a 2-bit prescaler chooses one bit of the incremented counter value. When that bit would become one, the counter returns to zero. Prescaler values 0, 1, 2 and 3 give periods of 128, 64, 32 and 16 ticks. At a 32 kHz tick these periods are 250 Hz, 500 Hz, 1 kHz and 2 kHz.

Software uses a byte-wide bus with a one-bit address, a write strobe and combinational read data. Address 0 is the control byte, which holds the enable and the prescaler. Address 1 is the duty byte, which holds a 7-bit compare value. The output is driven high while the counter is below the duty value. The counter is first masked to the bits under the reset bit. Polarity is fixed.

The block has these non-ideal behaviours, which are intended:
- Changing the prescaler does not clear the counter.
- A new duty value takes effect on the next cycle's compare, not at the end of the period.
- Prescaler 0 cannot reach 100 % duty, because the duty field tops out at 127.

When the block is disabled, the pin it shares with a general-purpose input simply passes that input through.

Top module: `bitsel_pwm`

## Requirements
- R1: After reset, both registers read 0x00 and the counter is zero. Enabling with prescaler 0 and duty 1, with no tick, therefore drives the output high.
- R2: The counter changes only on cycles where tickEn is high. Without ticks it holds its value.
- R3: With prescaler p, a tick that would make bit (7-p) of the counter one clears the counter instead. In steady state the period is 2^(7-p) ticks: 128, 64, 32 or 16.
- R4: Address 0 is the control register. Bit 7 is the enable and bits [1:0] are the prescaler. All other bits are ignored and read back as 0, so writing 0xFF reads back 0x83.
- R5: Address 1 is the duty register. It holds bits [6:0], and bit 7 reads back as 0, so writing 0xFF reads back 0x7F.
- R6: When enabled, the output is high exactly when (counter AND (2^(7-p)-1)) < duty. Duty 0 gives a constant low. Prescaler 1 with duty 127 gives a constant high. Prescaler 0 with duty 127 gives exactly one low tick per 128-tick period.
- R7: Writing a new prescaler leaves the counter value untouched. Counting continues from that value under the new reset bit.
- R8: A duty write is used by the compare in the very next cycle, even in the middle of a period.
- R9: When the enable bit is 0, the output equals gpioIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter advance enable (32 kHz rate) |
| wrEn | input | 1 | Register write strobe |
| addr | input | 1 | Register address: 0 is control, 1 is duty |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the register at addr |
| gpioIn | input | 1 | Fallback level for the shared pin |
| pwmOut | output | 1 | Shared pin: PWM when enabled, otherwise gpioIn |

## Verification
Two events can fall in the same clock edge: a register write and a counter tick, in particular the tick that wraps the counter. The bench provokes this in two ways. Directed cases write the prescaler and the duty value on the same cycle as a tick, including the case where the counter sits above the new range. A long pseudo-random phase then mixes ticks, writes to both addresses and gpio changes on every cycle. A behavioural model advances the counter under the prescaler that held before the edge and applies writes afterwards. The output and the read data are compared with this model on every cycle, which shows whether the edge ordering is right.

// File: rtl/bitsel_pwm_pkg.sv
package bitsel_pwm_pkg;
  localparam int CNT_W   = 8;
  localparam int PSC_W   = 2;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 1;
  localparam int DUTY_W  = CNT_W - 1;
  localparam int NUM_PSC = 1 << PSC_W;
  localparam int EN_BIT  = DATA_W - 1;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_DUTY = ADDR_W'(1);

  typedef struct packed {
    logic              enable;
    logic [PSC_W-1:0]  psc;
    logic [DUTY_W-1:0] duty;
  } pwmCfg_t;
endpackage

// File: rtl/bitsel_pwm_regs.sv
module bitsel_pwm_regs
  import bitsel_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output pwmCfg_t           cfg
);
  logic              enQ;
  logic [PSC_W-1:0]  pscQ;
  logic [DUTY_W-1:0] dutyQ;

  logic ctrlWr, dutyWr;
  assign ctrlWr = wrEn && (addr == ADDR_CTRL);
  assign dutyWr = wrEn && (addr == ADDR_DUTY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      pscQ  <= '0;
      dutyQ <= '0;
    end else begin
      if (ctrlWr) begin
        enQ  <= wrData[EN_BIT];
        pscQ <= wrData[PSC_W-1:0];
      end
      if (dutyWr) begin
        dutyQ <= wrData[DUTY_W-1:0];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_CTRL) begin
      rdData[EN_BIT]      = enQ;
      rdData[PSC_W-1:0]   = pscQ;
    end else if (addr == ADDR_DUTY) begin
      rdData[DUTY_W-1:0]  = dutyQ;
    end
  end

  assign cfg = '{enable: enQ, psc: pscQ, duty: dutyQ};
endmodule

// File: rtl/bitsel_pwm_core.sv
module bitsel_pwm_core
  import bitsel_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  pwmCfg_t          cfg,
  input  logic             gpioIn,
  output logic             pwmOut,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0]   cntQ;
  logic [CNT_W-1:0]   cntInc;
  logic [NUM_PSC-1:0] wrapVec;
  logic [CNT_W-1:0]   maskArr [NUM_PSC];
  logic               wrapNow;
  logic [CNT_W-1:0]   cntMasked;
  logic               pwmRaw;

  assign cntInc = cntQ + CNT_W'(1);

  // One reset-bit tap and one compare mask per prescaler setting
  for (genvar p = 0; p < NUM_PSC; p++) begin : g_sel
    localparam int RB = CNT_W - 1 - p;
    assign wrapVec[p] = cntInc[RB];
    assign maskArr[p] = CNT_W'((1 << RB) - 1);
  end

  assign wrapNow = wrapVec[cfg.psc];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (tickEn) begin
      cntQ <= wrapNow ? '0 : cntInc;
    end
  end

  assign cntMasked = cntQ & maskArr[cfg.psc];
  assign pwmRaw    = cntMasked < {1'b0, cfg.duty};
  assign pwmOut    = cfg.enable ? pwmRaw : gpioIn;
  assign cnt       = cntQ;
endmodule

// File: rtl/bitsel_pwm.sv
module bitsel_pwm
  import bitsel_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              gpioIn,
  output logic              pwmOut
);
  pwmCfg_t          cfg;
  logic [CNT_W-1:0] cntVal;

  bitsel_pwm_regs uRegs (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .cfg    (cfg)
  );

  bitsel_pwm_core uCore (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn),
    .cfg    (cfg),
    .gpioIn (gpioIn),
    .pwmOut (pwmOut),
    .cnt    (cntVal)
  );
endmodule

// File: rtl/bitsel_pwm_chk.sv
module bitsel_pwm_chk
  import bitsel_pwm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              gpioIn,
  input logic              pwmOut,
  input logic [CNT_W-1:0]  cnt,
  input pwmCfg_t           cfg
);
  logic [CNT_W-1:0] cntNext;
  logic             wrapDue;
  int               resetIdx;

  assign cntNext  = cnt + CNT_W'(1);
  assign resetIdx = CNT_W - 1 - int'(cfg.psc);
  assign wrapDue  = cntNext[resetIdx];

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(cnt));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && wrapDue) |=> (cnt == '0));

  assert_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !wrapDue) |=> (cnt == $past(cnt) + CNT_W'(1)));

  assert_ctrl_wr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_CTRL) |=>
      (cfg.enable == $past(wrData[EN_BIT]) && cfg.psc == $past(wrData[PSC_W-1:0])));

  assert_duty_top_R5: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_DUTY) |-> (rdData[DATA_W-1] == 1'b0));

  assert_zero_duty_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.enable && cfg.duty == '0) |-> !pwmOut);

  assert_start_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.enable && cnt == '0 && cfg.duty != '0) |-> pwmOut);

  assert_gpio_R9: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |-> (pwmOut == gpioIn));
endmodule

bind bitsel_pwm bitsel_pwm_chk uChk (
  .clk    (clk),
  .rstN   (rstN),
  .tickEn (tickEn),
  .wrEn   (wrEn),
  .addr   (addr),
  .wrData (wrData),
  .rdData (rdData),
  .gpioIn (gpioIn),
  .pwmOut (pwmOut),
  .cnt    (cntVal),
  .cfg    (cfg)
);

// File: tb/bitsel_pwm_test.sv
`timescale 1ns/1ps
module bitsel_pwm_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [0:0] addr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       gpioIn = 1'b0;
  logic       pwmOut;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string curReq = "R1";

  // reference model state
  int mCnt = 0;
  int mPsc = 0;
  int mDuty = 0;
  bit mEn = 0;

  always #2.5 clk = ~clk;

  bitsel_pwm uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .gpioIn(gpioIn), .pwmOut(pwmOut)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int expRead(input bit a);
    if (a == 1'b0) return (int'(mEn) << 7) | mPsc;
    return mDuty;
  endfunction

  function automatic bit expPwm(input bit g);
    int mask;
    if (!mEn) return g;
    mask = (1 << (7 - mPsc)) - 1;
    return ((mCnt & mask) < mDuty);
  endfunction

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit tk, input bit wr, input bit ad, input logic [7:0] d, input bit g);
    int n;
    tickEn = tk; wrEn = wr; addr = ad; wrData = d; gpioIn = g;
    @(posedge clk);
    if (tk) begin
      n = (mCnt + 1) & 255;
      if (((n >> (7 - mPsc)) & 1) == 1) mCnt = 0;
      else mCnt = n;
    end
    if (wr) begin
      if (ad == 1'b0) begin
        mEn = d[7];
        mPsc = int'(d[1:0]);
      end else begin
        mDuty = int'(d[6:0]);
      end
    end
    @(negedge clk);
    chk(curReq, int'(pwmOut), int'(expPwm(g)), "pwmOut");
    chk(curReq, int'(rdData), expRead(ad), "rdData");
  endtask

  task automatic idleTicks(input int n, input bit g);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 8'h00, g);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lows, highs, gap;
    bit g;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset values, output follows gpio while disabled
    curReq = "R1";
    chk("R1", int'(rdData), 0, "ctrl after reset");
    step(1'b0, 1'b0, 1'b1, 8'h00, 1'b1);
    chk("R1", int'(rdData), 0, "duty after reset");
    step(1'b0, 1'b1, 1'b1, 8'h01, 1'b0);
    step(1'b0, 1'b1, 1'b0, 8'h80, 1'b0);
    chk("R1", int'(pwmOut), 1, "counter zero after reset");

    // R2: counter holds without ticks
    curReq = "R2";
    step(1'b0, 1'b1, 1'b1, 8'h05, 1'b0);
    for (int i = 0; i < 40; i++) step((i % 3) == 0, 1'b0, 1'b0, 8'h00, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b1, 8'h00, 1'b0);

    // R3: period per prescaler, duty 1 => one high cycle per period
    curReq = "R3";
    for (int p = 0; p < 4; p++) begin
      step(1'b1, 1'b1, 1'b0, 8'h80 | 8'(p), 1'b0);
      step(1'b1, 1'b1, 1'b1, 8'h01, 1'b0);
      idleTicks(200, 1'b0);
      gap = 0;
      while (pwmOut != 1'b1 && gap < 300) begin idleTicks(1, 1'b0); gap++; end
      gap = 0;
      do begin idleTicks(1, 1'b0); gap++; end while (pwmOut != 1'b1 && gap < 300);
      chk("R3", gap, 1 << (7 - p), "period ticks");
    end

    // R6: duty corners
    curReq = "R6";
    step(1'b1, 1'b1, 1'b0, 8'h80, 1'b0);
    step(1'b1, 1'b1, 1'b1, 8'h7F, 1'b0);
    idleTicks(200, 1'b0);
    lows = 0;
    for (int i = 0; i < 128; i++) begin idleTicks(1, 1'b0); if (!pwmOut) lows++; end
    chk("R6", lows, 1, "p0 duty127 low ticks");
    step(1'b1, 1'b1, 1'b0, 8'h81, 1'b0);
    idleTicks(200, 1'b0);
    lows = 0;
    for (int i = 0; i < 64; i++) begin idleTicks(1, 1'b0); if (!pwmOut) lows++; end
    chk("R6", lows, 0, "p1 duty127 low ticks");
    step(1'b1, 1'b1, 1'b1, 8'h00, 1'b1);
    highs = 0;
    for (int i = 0; i < 64; i++) begin idleTicks(1, 1'b1); if (pwmOut) highs++; end
    chk("R6", highs, 0, "duty0 high ticks");
    step(1'b1, 1'b1, 1'b1, 8'd20, 1'b0);
    idleTicks(150, 1'b0);

    // R7: prescaler switch with counter above new range, on a tick cycle
    curReq = "R7";
    step(1'b1, 1'b1, 1'b0, 8'h80, 1'b0);
    idleTicks(250, 1'b0);
    while (mCnt != 100) idleTicks(1, 1'b0);
    step(1'b1, 1'b1, 1'b0, 8'h83, 1'b0);
    idleTicks(60, 1'b0);
    step(1'b0, 1'b1, 1'b0, 8'h80, 1'b0);
    idleTicks(40, 1'b0);

    // R8: duty change mid-period and on the wrap tick
    curReq = "R8";
    step(1'b1, 1'b1, 1'b0, 8'h82, 1'b0);
    step(1'b1, 1'b1, 1'b1, 8'd4, 1'b0);
    while (mCnt != 10) idleTicks(1, 1'b0);
    step(1'b0, 1'b1, 1'b1, 8'd30, 1'b0);
    chk("R8", int'(pwmOut), 1, "duty raised mid-period");
    step(1'b0, 1'b1, 1'b1, 8'd5, 1'b0);
    chk("R8", int'(pwmOut), 0, "duty lowered mid-period");
    while (mCnt != 31) idleTicks(1, 1'b0);
    step(1'b1, 1'b1, 1'b1, 8'd12, 1'b0);
    idleTicks(40, 1'b0);

    // R4 / R5: unused bits ignored
    curReq = "R4";
    step(1'b0, 1'b1, 1'b0, 8'hFF, 1'b0);
    chk("R4", int'(rdData), 8'h83, "ctrl readback");
    curReq = "R5";
    step(1'b0, 1'b1, 1'b1, 8'hFF, 1'b0);
    chk("R5", int'(rdData), 8'h7F, "duty readback");

    // R9: disabled output follows gpio
    curReq = "R9";
    step(1'b1, 1'b1, 1'b0, 8'h02, 1'b0);
    for (int i = 0; i < 30; i++) begin
      g = (i % 4) < 2;
      step(1'b1, 1'b0, 1'b0, 8'h00, g);
      chk("R9", int'(pwmOut), int'(g), "gpio passthrough");
    end

    // R7: mixed ticks and writes colliding on the same edges
    curReq = "R7";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step(($urandom_range(0, 3) != 0), (r < 8), r[0], 8'($urandom_range(0, 255)),
           ($urandom_range(0, 1) == 1));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule